// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block executes five 32-bit data-processing operations (add, bitwise test, bitwise equivalence test, compare and inclusive OR) for a processor execute stage. Its first operand comes from the register named by the Rn index, or from the pipelined program counter when that index is 15. Its second operand and the carry produced by the shifter arrive already prepared. It returns the result, a write strobe and index for the destination register, the negative/zero/carry/overflow status flags it holds, and a pulse that marks an unsupported request.

A request is presented with `valid_i` for one cycle. The result, the strobes and the updated flags appear on the outputs one clock later. Test and compare operations change only the flags. Add and OR write the destination and change the flags only when asked to. A request that sets flags while naming register 15 as destination, and any opcode outside the five, is refused. A refused request leaves the result, the flags and the register file untouched.

Top module: `dp_alu_top`

## Requirements
- R1: During and right after reset, `result_o` is 0, `rd_we_o` and `err_o` are 0, and `flags_o` is 0.
- R2: A request sampled with `valid_i` at a rising edge produces its outputs after that same edge. `rd_we_o` and `err_o` are high for that one cycle only. While `valid_i` is low, `flags_o` and `result_o` hold and both strobes stay low. `flags_o` is packed N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R3: Operand1 is `rn_data_i`, except when `rn_i` is 15: then it is `pc_i + 8`, and `rn_data_i` is ignored.
- R4: Opcode 4'h4 (add) writes op1+op2 to `result_o` and raises `rd_we_o`, with `rd_idx_o` equal to `rd_i`. When `set_flags_i` is 1 and `rd_i` is not 15, it sets N to result bit 31, Z to result==0, C to the unsigned carry out of bit 31 and V to the signed overflow.
- R5: Opcode 4'hC (OR) writes op1|op2 and raises `rd_we_o`. When `set_flags_i` is 1 and `rd_i` is not 15, it sets N and Z from the result and C from `shift_carry_i`, and keeps V.
- R6: Add or OR with `set_flags_i` at 0 leaves `flags_o` unchanged. This also allows `rd_i` of 15, which is then written.
- R7: Opcode 4'h8 (AND test) and 4'h9 (XOR test) never raise `rd_we_o`. They set N and Z from the result and C from `shift_carry_i`, and keep V. `result_o` shows the result.
- R8: Opcode 4'hA (compare) computes op1-op2 and never raises `rd_we_o`. It sets N and Z from the result and C when op2 <= op1 unsigned. V is bit 31 of ((op1 ^ res) & (~op2 ^ res)).
- R9: `set_flags_i` at 1 together with `rd_i` of 15 pulses `err_o`, suppresses `rd_we_o`, and leaves `flags_o` and `result_o` unchanged.
- R10: Any opcode other than 4'h4, 4'h8, 4'h9, 4'hA or 4'hC pulses `err_o`, suppresses `rd_we_o`, and leaves `flags_o` and `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Update flags for add/OR |
| rd_i | input | 4 | Destination register index |
| rn_i | input | 4 | First operand register index |
| rn_data_i | input | 32 | Register file read data for Rn |
| pc_i | input | 32 | Address of the current instruction |
| op2_i | input | 32 | Second operand from the shifter |
| shift_carry_i | input | 1 | Carry out of the shifter |
| result_o | output | 32 | Last accepted result |
| rd_we_o | output | 1 | Destination write strobe |
| rd_idx_o | output | 4 | Destination index for the write |
| flags_o | output | 4 | Status flags N,Z,C,V |
| err_o | output | 1 | Unsupported request pulse |

## Verification
All results of a request become visible one clock edge after the edge that samples it: the result, the strobes and the flags alike. The bench drives each request on a falling edge and checks the outputs on the next falling edge, halfway between the register update and the following edge. It then drops `valid_i` and checks one more falling edge later. There the strobes must have fallen while flags and result hold, which covers the one-cycle pulse rule.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OPC_ADD = 4'h4,
      OPC_TST = 4'h8,
      OPC_TEQ = 4'h9,
      OPC_CMP = 4'hA,
      OPC_ORR = 4'hC
   } dp_opc_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } dp_flags_t;

endpackage

// File: rtl/dp_op1_sel.sv
module dp_op1_sel #(
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4,
   parameter int PC_IDX    = 15,
   parameter int PC_AHEAD  = 8
) (
   input  logic [IDX_W-1:0]  rn_i,
   input  logic [DATA_W-1:0] rn_data_i,
   input  logic [DATA_W-1:0] pc_i,
   output logic [DATA_W-1:0] op1_o
);
   localparam logic [IDX_W-1:0]  PC_SEL = IDX_W'(PC_IDX);
   localparam logic [DATA_W-1:0] AHEAD  = DATA_W'(PC_AHEAD);

   logic [DATA_W-1:0] pc_view;

   generate
      if (PC_AHEAD == 0) begin : g_pc_plain
         assign pc_view = pc_i;
      end else begin : g_pc_ahead
         assign pc_view = pc_i + AHEAD;
      end
   endgenerate

   assign op1_o = (rn_i == PC_SEL) ? pc_view : rn_data_i;

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 15
) (
   input  logic [3:0]        opcode_i,
   input  logic              set_flags_i,
   input  logic [IDX_W-1:0]  rd_i,
   input  logic [DATA_W-1:0] op1_i,
   input  logic [DATA_W-1:0] op2_i,
   input  logic              shift_carry_i,
   input  dp_flags_t         flags_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_rd_o,
   output logic              wr_flags_o,
   output logic              wr_res_o,
   output dp_flags_t         flags_o,
   output logic              illegal_o
);
   localparam int               MSB    = DATA_W - 1;
   localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

   logic [DATA_W:0]   sum_w;
   logic [DATA_W-1:0] diff_w;
   logic              pc_s_clash;

   assign sum_w      = {1'b0, op1_i} + {1'b0, op2_i};
   assign diff_w     = op1_i - op2_i;
   assign pc_s_clash = set_flags_i && (rd_i == PC_SEL);

   always_comb begin
      res_o      = '0;
      wr_rd_o    = 1'b0;
      wr_flags_o = 1'b0;
      wr_res_o   = 1'b0;
      illegal_o  = 1'b0;
      flags_o    = flags_i;
      if (pc_s_clash) begin
         illegal_o = 1'b1;
      end else begin
         case (opcode_i)
            OPC_ADD: begin
               res_o      = sum_w[MSB:0];
               wr_rd_o    = 1'b1;
               wr_res_o   = 1'b1;
               wr_flags_o = set_flags_i;
               flags_o.c  = sum_w[DATA_W];
               flags_o.v  = (op1_i[MSB] == op2_i[MSB]) && (sum_w[MSB] != op1_i[MSB]);
            end
            OPC_ORR: begin
               res_o      = op1_i | op2_i;
               wr_rd_o    = 1'b1;
               wr_res_o   = 1'b1;
               wr_flags_o = set_flags_i;
               flags_o.c  = shift_carry_i;
            end
            OPC_TST: begin
               res_o      = op1_i & op2_i;
               wr_res_o   = 1'b1;
               wr_flags_o = 1'b1;
               flags_o.c  = shift_carry_i;
            end
            OPC_TEQ: begin
               res_o      = op1_i ^ op2_i;
               wr_res_o   = 1'b1;
               wr_flags_o = 1'b1;
               flags_o.c  = shift_carry_i;
            end
            OPC_CMP: begin
               res_o      = diff_w;
               wr_res_o   = 1'b1;
               wr_flags_o = 1'b1;
               flags_o.c  = (op2_i <= op1_i);
               flags_o.v  = ((op1_i[MSB] ^ diff_w[MSB]) & (~op2_i[MSB] ^ diff_w[MSB]));
            end
            default: illegal_o = 1'b1;
         endcase
         flags_o.n = res_o[MSB];
         flags_o.z = (res_o == '0);
      end
   end

   always_comb begin
      if (illegal_o) begin
         a_r10_no_write_when_illegal: assert (!wr_rd_o && !wr_flags_o && !wr_res_o)
            else $error("illegal request still writes");
      end
   end

endmodule

// File: rtl/dp_alu_top.sv
module dp_alu_top
   import dp_alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 4,
   parameter int PC_IDX   = 15,
   parameter int PC_AHEAD = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [3:0]        opcode_i,
   input  logic              set_flags_i,
   input  logic [IDX_W-1:0]  rd_i,
   input  logic [IDX_W-1:0]  rn_i,
   input  logic [DATA_W-1:0] rn_data_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] op2_i,
   input  logic              shift_carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              rd_we_o,
   output logic [IDX_W-1:0]  rd_idx_o,
   output logic [3:0]        flags_o,
   output logic              err_o
);
   localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

   initial begin
      a_param_width: assert (DATA_W >= 8) else $error("DATA_W too small");
      a_param_pc:    assert (PC_IDX < (1 << IDX_W)) else $error("PC_IDX out of range");
   end

   logic [DATA_W-1:0] op1_w, res_w;
   logic              wr_rd_w, wr_flags_w, wr_res_w, illegal_w;
   dp_flags_t         flags_q, flags_nxt;

   dp_op1_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD)) op1_i (
      .rn_i      (rn_i),
      .rn_data_i (rn_data_i),
      .pc_i      (pc_i),
      .op1_o     (op1_w)
   );

   dp_alu_core #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) core_i (
      .opcode_i      (opcode_i),
      .set_flags_i   (set_flags_i),
      .rd_i          (rd_i),
      .op1_i         (op1_w),
      .op2_i         (op2_i),
      .shift_carry_i (shift_carry_i),
      .flags_i       (flags_q),
      .res_o         (res_w),
      .wr_rd_o       (wr_rd_w),
      .wr_flags_o    (wr_flags_w),
      .wr_res_o      (wr_res_w),
      .flags_o       (flags_nxt),
      .illegal_o     (illegal_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         rd_we_o  <= 1'b0;
         rd_idx_o <= '0;
         flags_q  <= '0;
         err_o    <= 1'b0;
      end else begin
         rd_we_o <= valid_i && wr_rd_w;
         err_o   <= valid_i && illegal_w;
         if (valid_i) rd_idx_o <= rd_i;
         if (valid_i && wr_res_w) result_o <= res_w;
         if (valid_i && wr_flags_w) flags_q <= flags_nxt;
      end
   end

   assign flags_o = flags_q;

   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (!rd_we_o && !err_o && $stable(flags_o) && $stable(result_o)))
      else $error("idle cycle changed state");

   a_r2_err_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !rd_we_o)
      else $error("error and write together");

   a_r7_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (opcode_i == OPC_TST || opcode_i == OPC_TEQ)) |=>
         (flags_o[0] == $past(flags_o[0]) && !rd_we_o))
      else $error("test op touched V or Rd");

   a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && opcode_i == OPC_CMP) |=> !rd_we_o)
      else $error("compare wrote Rd");

   a_r9_pc_s_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && set_flags_i && rd_i == PC_SEL) |=>
         (err_o && !rd_we_o && $stable(flags_o)))
      else $error("S with Rd=15 not refused");

endmodule

// File: tb/dp_alu_top_tb_top.sv
module dp_alu_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [3:0]  opcode_i = '0;
   logic        set_flags_i = 1'b0;
   logic [3:0]  rd_i = '0, rn_i = '0;
   logic [31:0] rn_data_i = '0, pc_i = '0, op2_i = '0;
   logic        shift_carry_i = 1'b0;
   logic [31:0] result_o;
   logic        rd_we_o, err_o;
   logic [3:0]  rd_idx_o, flags_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dp_alu_top dut_i (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
      .set_flags_i(set_flags_i), .rd_i(rd_i), .rn_i(rn_i), .rn_data_i(rn_data_i),
      .pc_i(pc_i), .op2_i(op2_i), .shift_carry_i(shift_carry_i),
      .result_o(result_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
      .flags_o(flags_o), .err_o(err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one request, check the cycle after, then check an idle cycle (R2)
   task automatic run(input string req, input logic [3:0] opc, input logic s,
                      input logic [3:0] rd, input logic [3:0] rn, input logic [31:0] rnd,
                      input logic [31:0] pc, input logic [31:0] op2, input logic sc,
                      input logic [31:0] e_res, input logic e_we, input logic e_err,
                      input logic [3:0] e_flags);
      @(negedge clk);
      valid_i = 1'b1; opcode_i = opc; set_flags_i = s; rd_i = rd; rn_i = rn;
      rn_data_i = rnd; pc_i = pc; op2_i = op2; shift_carry_i = sc;
      @(negedge clk);
      valid_i = 1'b0;
      chk({req, " result"}, result_o, e_res);
      chk({req, " we"}, 32'(rd_we_o), 32'(e_we));
      chk({req, " err"}, 32'(err_o), 32'(e_err));
      chk({req, " flags"}, 32'(flags_o), 32'(e_flags));
      if (e_we) chk({req, " rd_idx"}, 32'(rd_idx_o), 32'(rd));
      @(negedge clk);
      chk("R2 idle we", 32'(rd_we_o), 32'd0);
      chk("R2 idle err", 32'(err_o), 32'd0);
      chk("R2 idle flags", 32'(flags_o), 32'(e_flags));
      chk("R2 idle result", result_o, e_res);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 result", result_o, 32'd0);
      chk("R1 we", 32'(rd_we_o), 32'd0);
      chk("R1 err", 32'(err_o), 32'd0);
      chk("R1 flags", 32'(flags_o), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({flags_o, rd_we_o, err_o}), 32'd0);
   endtask

   task automatic t_add();
      run("R4 add carry", 4'h4, 1, 4'd2, 4'd1, 32'hFFFF_FFFF, 32'h0, 32'h1, 0, 32'h0, 1, 0, 4'b0110);
      run("R4 add overflow", 4'h4, 1, 4'd2, 4'd1, 32'h7FFF_FFFF, 32'h0, 32'h1, 0, 32'h8000_0000, 1, 0, 4'b1001);
      run("R6 add no S", 4'h4, 0, 4'd3, 4'd1, 32'd5, 32'h0, 32'd6, 0, 32'd11, 1, 0, 4'b1001);
   endtask

   task automatic t_pc_operand();
      run("R3 add pc+8", 4'h4, 0, 4'd3, 4'd15, 32'h0000_DEAD, 32'h100, 32'h4, 0, 32'h10C, 1, 0, 4'b1001);
   endtask

   task automatic t_orr();
      run("R5 orr S", 4'hC, 1, 4'd4, 4'd2, 32'hF0, 32'h0, 32'h0F, 1, 32'hFF, 1, 0, 4'b0011);
      run("R6 orr no S", 4'hC, 0, 4'd4, 4'd2, 32'h0, 32'h0, 32'h0, 0, 32'h0, 1, 0, 4'b0011);
   endtask

   task automatic t_test_ops();
      run("R7 tst", 4'h8, 1, 4'd0, 4'd1, 32'hFF00, 32'h0, 32'h00FF, 0, 32'h0, 0, 0, 4'b0101);
      run("R7 teq", 4'h9, 1, 4'd0, 4'd1, 32'h8000_0001, 32'h0, 32'h1, 1, 32'h8000_0000, 0, 0, 4'b1011);
   endtask

   task automatic t_cmp();
      run("R8 cmp equal", 4'hA, 1, 4'd0, 4'd1, 32'd5, 32'h0, 32'd5, 0, 32'h0, 0, 0, 4'b0110);
      run("R8 cmp borrow", 4'hA, 1, 4'd0, 4'd1, 32'd3, 32'h0, 32'd5, 0, 32'hFFFF_FFFE, 0, 0, 4'b1000);
      run("R8 cmp overflow", 4'hA, 1, 4'd0, 4'd1, 32'h8000_0000, 32'h0, 32'h1, 0, 32'h7FFF_FFFF, 0, 0, 4'b0011);
      run("R3 cmp pc+8", 4'hA, 1, 4'd0, 4'd15, 32'h55, 32'h10, 32'h18, 0, 32'h0, 0, 0, 4'b0110);
   endtask

   task automatic t_errors();
      run("R9 add S rd15", 4'h4, 1, 4'd15, 4'd1, 32'h1, 32'h0, 32'h1, 1, 32'h0, 0, 1, 4'b0110);
      run("R9 tst S rd15", 4'h8, 1, 4'd15, 4'd1, 32'h0, 32'h0, 32'h0, 1, 32'h0, 0, 1, 4'b0110);
      run("R6 add rd15 no S", 4'h4, 0, 4'd15, 4'd1, 32'h20, 32'h0, 32'h4, 0, 32'h24, 1, 0, 4'b0110);
      run("R10 opcode 0", 4'h0, 0, 4'd2, 4'd1, 32'h1, 32'h0, 32'h0, 1, 32'h24, 0, 1, 4'b0110);
      run("R10 opcode F", 4'hF, 1, 4'd2, 4'd1, 32'h0, 32'h0, 32'h0, 1, 32'h24, 0, 1, 4'b0110);
   endtask

   initial begin
      t_reset();
      t_add();
      t_pc_operand();
      t_orr();
      t_test_ops();
      t_cmp();
      t_errors();
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule